// File: doc/BRIEF.md
# Oscillator control and status register

This block is one byte-wide control and status register for a clock subsystem. Software sees it on a simple register bus. A write is a single-cycle `wr_en` strobe with a data byte. The current register value is always on `rd_data`. Hardware event pulses from the clock-switch logic, the PLL and the fail-safe clock monitor drive three status bits: a PLL lock indicator, a clock-fail flag and an oscillator-switch request. Each of these bits has its own rules for set, clear and read masking. Two plain control bits enable clock dither and the trim tune sequencer.

The block also selects the 4-bit oscillator trim value. When the tune sequencer is off, the base tune field drives the trim. When it is on, a 3-bit roll index from an outside module picks one of eight tune fields.

Top module: `osc_ctrl_reg`

## Requirements
- R1: An asserted `rst_n` (power-on reset) clears every register bit. Afterwards `rd_data`, `sw_req`, `dither_en` and `tseq_en` are all 0.
- R2: `rd_data` bits 7:6 and bit 1 always read 0, and writes to them are ignored. Bit 4 (dither enable) and bit 2 (tune-sequencer enable) load from a write. They read back on `rd_data` and appear on `dither_en` and `tseq_en` from the cycle after the write.
- R3: The lock state (bit 5) sets on `ev_lock_gain`. It clears on `ev_sw_start` or `ev_lock_lost`, and a clear wins over a coincident gain. Software writes never change it.
- R4: While `pll_is_sysclk` is 0, bit 5 of `rd_data` reads 0 and the lock state is kept. Once `pll_is_sysclk` returns to 1, bit 5 shows the kept state again.
- R5: The clock-fail flag (bit 3) sets on `ev_fail_detect`. It clears on `ev_sw_start` or on a write with data bit 3 = 0. A write with bit 3 = 1 does not set it.
- R6: When `ev_fail_detect` coincides with any clear of the clock-fail flag, the flag ends up set.
- R7: The switch request (bit 0, also on `sw_req`) sets on a write with data bit 0 = 1. A write with bit 0 = 0 leaves it unchanged. It clears on `ev_sw_done`, `ev_sw_redundant` or `ev_fsm_to_rc`.
- R8: When a switch-request clear event coincides with a write of bit 0 = 1, the request ends up clear.
- R9: `trim_out` is `tune_fields[3:0]` while `tseq_en` is 0. While `tseq_en` is 1 it is `tune_fields[4k+3:4k]` with k = `roll_idx`. The path is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Current register view, with masking applied |
| ev_sw_start | input | 1 | Pulse: a valid clock-switch sequence begins |
| ev_sw_done | input | 1 | Pulse: switch completed successfully |
| ev_sw_redundant | input | 1 | Pulse: requested switch was redundant |
| ev_lock_gain | input | 1 | Pulse: PLL reached lock after start |
| ev_lock_lost | input | 1 | Pulse: PLL lost lock |
| ev_fail_detect | input | 1 | Pulse: fail-safe monitor saw a clock failure |
| ev_fsm_to_rc | input | 1 | Pulse: fail-safe monitor forced the internal RC clock |
| pll_is_sysclk | input | 1 | Level: PLL is the selected system clock |
| tune_fields | input | 32 | Eight 4-bit tune fields, field k at bits 4k+3:4k |
| roll_idx | input | 3 | Tune field index from an outside module |
| trim_out | output | 4 | Selected oscillator trim value |
| dither_en | output | 1 | Dither enable state |
| tseq_en | output | 1 | Tune-sequencer enable state |
| sw_req | output | 1 | Pending oscillator-switch request |

## Verification
The properties assume that every event input is a single-cycle pulse aligned to `clk`, that `pll_is_sysclk` changes only between edges, and that `rst_n` is released away from a clock edge. The bench changes all inputs on the falling edge. Between directed sequences it clears every pulse after one cycle. The random phase draws each event with low probability and a random `pll_is_sysclk` level, so coincident set and clear cases occur often without breaking the single-cycle pulse assumption.

// File: rtl/osc_ctrl_pkg.sv
package osc_ctrl_pkg;

  // Bit positions of the software-visible register byte
  localparam int BIT_REQ  = 0;
  localparam int BIT_NONE = 1;
  localparam int BIT_TSEQ = 2;
  localparam int BIT_CF   = 3;
  localparam int BIT_DITH = 4;
  localparam int BIT_LOCK = 5;
  localparam int MIN_DATA_W = 6;

  // Hardware event pulses, one cycle wide, synchronous to clk
  typedef struct packed {
    logic sw_start;
    logic sw_done;
    logic sw_redundant;
    logic lock_gain;
    logic lock_lost;
    logic fail_detect;
    logic fsm_to_rc;
  } osc_evt_t;

endpackage

// File: rtl/osc_status_bits.sv
module osc_status_bits
  import osc_ctrl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  osc_evt_t evt,
  input  logic     wr_en,
  input  logic     wr_cf_bit,
  output logic     lock_q,
  output logic     cf_q
);

  logic lock_d, lock_en;
  logic cf_d, cf_en;
  logic lock_clr, cf_sw_clr, cf_clr;

  // Lock state: clear events outrank a gain
  assign lock_clr = evt.sw_start | evt.lock_lost;
  assign lock_en  = lock_clr | evt.lock_gain;

  always_comb begin
    lock_d = lock_q;
    if (lock_clr) begin
      lock_d = 1'b0;
    end else if (evt.lock_gain) begin
      lock_d = 1'b1;
    end
  end

  // Clock-fail flag: monitor set outranks every clear, software can only clear
  assign cf_sw_clr = wr_en & ~wr_cf_bit;
  assign cf_clr    = evt.sw_start | cf_sw_clr;
  assign cf_en     = cf_clr | evt.fail_detect;

  always_comb begin
    cf_d = cf_q;
    if (evt.fail_detect) begin
      cf_d = 1'b1;
    end else if (cf_clr) begin
      cf_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else if (lock_en) begin
      lock_q <= lock_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cf_q <= 1'b0;
    end else if (cf_en) begin
      cf_q <= cf_d;
    end
  end

endmodule

// File: rtl/osc_swreq_bit.sv
module osc_swreq_bit
  import osc_ctrl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  osc_evt_t evt,
  input  logic     wr_en,
  input  logic     wr_req_bit,
  output logic     req_q
);

  logic req_d, req_en;
  logic hw_clr, sw_set;

  assign hw_clr = evt.sw_done | evt.sw_redundant | evt.fsm_to_rc;
  assign sw_set = wr_en & wr_req_bit;
  assign req_en = hw_clr | sw_set;

  // A hardware clear outranks a software request in the same cycle
  always_comb begin
    req_d = req_q;
    if (hw_clr) begin
      req_d = 1'b0;
    end else if (sw_set) begin
      req_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else if (req_en) begin
      req_q <= req_d;
    end
  end

endmodule

// File: rtl/osc_trim_sel.sv
module osc_trim_sel #(
  parameter int TUNE_W   = 4,
  parameter int NUM_TUNE = 8,
  parameter int ROLL_W   = $clog2(NUM_TUNE)
) (
  input  logic [TUNE_W*NUM_TUNE-1:0] tune_fields,
  input  logic [ROLL_W-1:0]          roll_idx,
  input  logic                       seq_en,
  output logic [TUNE_W-1:0]          trim
);

  localparam int SLOTS = 1 << ROLL_W;

  logic [TUNE_W-1:0] field [SLOTS];
  logic [TUNE_W-1:0] rolled;

  // Unpack the fields; slots past NUM_TUNE fall back to the base field
  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_field
      if (g < NUM_TUNE) begin : g_real
        assign field[g] = tune_fields[g*TUNE_W +: TUNE_W];
      end else begin : g_pad
        assign field[g] = tune_fields[TUNE_W-1:0];
      end
    end
  endgenerate

  assign rolled = field[roll_idx];

  always_comb begin
    if (seq_en) begin
      trim = rolled;
    end else begin
      trim = field[0];
    end
  end

endmodule

// File: rtl/osc_ctrl_reg.sv
module osc_ctrl_reg
  import osc_ctrl_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int TUNE_W   = 4,
  parameter int NUM_TUNE = 8,
  parameter int ROLL_W   = $clog2(NUM_TUNE)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [DATA_W-1:0]          rd_data,
  input  logic                       ev_sw_start,
  input  logic                       ev_sw_done,
  input  logic                       ev_sw_redundant,
  input  logic                       ev_lock_gain,
  input  logic                       ev_lock_lost,
  input  logic                       ev_fail_detect,
  input  logic                       ev_fsm_to_rc,
  input  logic                       pll_is_sysclk,
  input  logic [TUNE_W*NUM_TUNE-1:0] tune_fields,
  input  logic [ROLL_W-1:0]          roll_idx,
  output logic [TUNE_W-1:0]          trim_out,
  output logic                       dither_en,
  output logic                       tseq_en,
  output logic                       sw_req
);

  osc_evt_t evt;
  logic     lock_q, cf_q, req_q;
  logic     dith_q, dith_d;
  logic     tseq_q, tseq_d;
  logic     ctrl_en;

  assign evt = '{sw_start:     ev_sw_start,
                 sw_done:      ev_sw_done,
                 sw_redundant: ev_sw_redundant,
                 lock_gain:    ev_lock_gain,
                 lock_lost:    ev_lock_lost,
                 fail_detect:  ev_fail_detect,
                 fsm_to_rc:    ev_fsm_to_rc};

  osc_status_bits u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .wr_en     (wr_en),
    .wr_cf_bit (wr_data[BIT_CF]),
    .lock_q    (lock_q),
    .cf_q      (cf_q)
  );

  osc_swreq_bit u_swreq (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (evt),
    .wr_en      (wr_en),
    .wr_req_bit (wr_data[BIT_REQ]),
    .req_q      (req_q)
  );

  // Plain read/write control bits
  assign ctrl_en = wr_en;

  always_comb begin
    dith_d = wr_data[BIT_DITH];
    tseq_d = wr_data[BIT_TSEQ];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dith_q <= 1'b0;
      tseq_q <= 1'b0;
    end else if (ctrl_en) begin
      dith_q <= dith_d;
      tseq_q <= tseq_d;
    end
  end

  osc_trim_sel #(
    .TUNE_W   (TUNE_W),
    .NUM_TUNE (NUM_TUNE),
    .ROLL_W   (ROLL_W)
  ) u_trim (
    .tune_fields (tune_fields),
    .roll_idx    (roll_idx),
    .seq_en      (tseq_q),
    .trim        (trim_out)
  );

  // Read view: lock hidden unless the PLL drives the system clock
  always_comb begin
    rd_data           = '0;
    rd_data[BIT_LOCK] = lock_q & pll_is_sysclk;
    rd_data[BIT_DITH] = dith_q;
    rd_data[BIT_CF]   = cf_q;
    rd_data[BIT_TSEQ] = tseq_q;
    rd_data[BIT_NONE] = 1'b0;
    rd_data[BIT_REQ]  = req_q;
  end

  assign dither_en = dith_q;
  assign tseq_en   = tseq_q;
  assign sw_req    = req_q;

endmodule

// File: rtl/osc_ctrl_reg_chk.sv
module osc_ctrl_reg_chk
  import osc_ctrl_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int TUNE_W   = 4,
  parameter int NUM_TUNE = 8,
  parameter int ROLL_W   = $clog2(NUM_TUNE)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic [DATA_W-1:0]          wr_data,
  input logic [DATA_W-1:0]          rd_data,
  input logic                       ev_sw_start,
  input logic                       ev_sw_done,
  input logic                       ev_sw_redundant,
  input logic                       ev_lock_gain,
  input logic                       ev_lock_lost,
  input logic                       ev_fail_detect,
  input logic                       ev_fsm_to_rc,
  input logic                       pll_is_sysclk,
  input logic [TUNE_W*NUM_TUNE-1:0] tune_fields,
  input logic [ROLL_W-1:0]          roll_idx,
  input logic [TUNE_W-1:0]          trim_out,
  input logic                       dither_en,
  input logic                       tseq_en,
  input logic                       sw_req
);

  logic req_hw_clr;
  assign req_hw_clr = ev_sw_done | ev_sw_redundant | ev_fsm_to_rc;

  p_zero_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[BIT_NONE] == 1'b0) && (rd_data[DATA_W-1:MIN_DATA_W] == '0));

  p_ctrl_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (dither_en == $past(wr_data[BIT_DITH])) && (tseq_en == $past(wr_data[BIT_TSEQ])));

  p_lock_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sw_start || ev_lock_lost) |=> !rd_data[BIT_LOCK]);

  p_lock_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_is_sysclk |-> !rd_data[BIT_LOCK]);

  p_cf_no_sw_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[BIT_CF] && !ev_fail_detect && !rd_data[BIT_CF]) |=> !rd_data[BIT_CF]);

  p_cf_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fail_detect |=> rd_data[BIT_CF]);

  p_req_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[BIT_REQ] && !req_hw_clr) |=> sw_req);

  p_req_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_hw_clr |=> !sw_req);

  p_req_mirror_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req == rd_data[BIT_REQ]);

  p_trim_base_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tseq_en |-> (trim_out == tune_fields[TUNE_W-1:0]));

endmodule

bind osc_ctrl_reg osc_ctrl_reg_chk #(
  .DATA_W   (DATA_W),
  .TUNE_W   (TUNE_W),
  .NUM_TUNE (NUM_TUNE),
  .ROLL_W   (ROLL_W)
) u_chk (.*);

// File: tb/tb_osc_ctrl_reg.sv
`timescale 1ns/1ps
module tb_osc_ctrl_reg;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_data;
  logic [7:0]  rd_data;
  logic        ev_sw_start, ev_sw_done, ev_sw_redundant;
  logic        ev_lock_gain, ev_lock_lost, ev_fail_detect, ev_fsm_to_rc;
  logic        pll_is_sysclk;
  logic [31:0] tune_fields;
  logic [2:0]  roll_idx;
  logic [3:0]  trim_out;
  logic        dither_en, tseq_en, sw_req;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // Bench model of the register state
  logic m_lock, m_cf, m_req, m_dith, m_tseq;

  osc_ctrl_reg dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ev_sw_start(ev_sw_start), .ev_sw_done(ev_sw_done), .ev_sw_redundant(ev_sw_redundant),
    .ev_lock_gain(ev_lock_gain), .ev_lock_lost(ev_lock_lost), .ev_fail_detect(ev_fail_detect),
    .ev_fsm_to_rc(ev_fsm_to_rc), .pll_is_sysclk(pll_is_sysclk), .tune_fields(tune_fields),
    .roll_idx(roll_idx), .trim_out(trim_out), .dither_en(dither_en), .tseq_en(tseq_en),
    .sw_req(sw_req)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] exp_rd();
    return {2'b00, m_lock & pll_is_sysclk, m_dith, m_cf, m_tseq, 1'b0, m_req};
  endfunction

  function automatic logic [3:0] exp_trim(logic [31:0] f, logic [2:0] r, logic s);
    return s ? f[r*4 +: 4] : f[3:0];
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Model update from the requirements, applied at each rising edge
  task automatic model_step();
    logic [7:0] e;
    e = exp_rd();
    if (ev_sw_start || ev_lock_lost) m_lock = 1'b0;
    else if (ev_lock_gain)           m_lock = 1'b1;
    if (ev_fail_detect)                                  m_cf = 1'b1;
    else if (ev_sw_start || (wr_en && !wr_data[3]))      m_cf = 1'b0;
    if (ev_sw_done || ev_sw_redundant || ev_fsm_to_rc)   m_req = 1'b0;
    else if (wr_en && wr_data[0])                        m_req = 1'b1;
    if (wr_en) begin
      m_dith = wr_data[4];
      m_tseq = wr_data[2];
    end
    if (e == 8'hxx) m_lock = m_lock;
  endtask

  task automatic clear_pulses();
    wr_en = 0; wr_data = 8'h00;
    ev_sw_start = 0; ev_sw_done = 0; ev_sw_redundant = 0;
    ev_lock_gain = 0; ev_lock_lost = 0; ev_fail_detect = 0; ev_fsm_to_rc = 0;
  endtask

  task automatic compare_all();
    logic [7:0] e;
    e = exp_rd();
    check(pll_is_sysclk ? "R3 lock bit" : "R4 lock mask", {7'd0, rd_data[5]}, {7'd0, e[5]});
    check("R5 clock-fail bit", {7'd0, rd_data[3]}, {7'd0, e[3]});
    check("R7 switch request", {6'd0, sw_req, rd_data[0]}, {6'd0, m_req, e[0]});
    check("R2 control bits", {4'd0, dither_en, tseq_en, rd_data[4], rd_data[2]},
          {4'd0, m_dith, m_tseq, e[4], e[2]});
    check("R2 zero bits", {5'd0, rd_data[7:6], rd_data[1]}, 8'd0);
  endtask

  // Inputs are set at a falling edge; one rising edge; sample at next falling edge
  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    clear_pulses();
    compare_all();
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1; wr_data = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    clear_pulses();
    pll_is_sysclk = 1; tune_fields = 32'h7654_3210; roll_idx = 0;
    m_lock = 0; m_cf = 0; m_req = 0; m_dith = 0; m_tseq = 0;
    rst_n = 0;
    #1;
    // R1: reset state
    check("R1 reset rd_data", rd_data, 8'h00);
    check("R1 reset outputs", {5'd0, sw_req, dither_en, tseq_en}, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", rd_data, 8'h00);

    // R2: write all ones: lock and cf untouched, unused bits zero
    wr(8'hFF); tick();
    check("R2 write ff", rd_data, 8'h15);
    wr(8'h00); tick();
    check("R2 write 00 keeps request", rd_data, 8'h01);
    ev_sw_done = 1; tick();

    // R3: lock gain, write ignored, lost, coincident gain+start
    ev_lock_gain = 1; tick();
    check("R3 lock set", {7'd0, rd_data[5]}, 8'd1);
    wr(8'h00); tick();
    check("R3 write keeps lock", {7'd0, rd_data[5]}, 8'd1);
    ev_lock_lost = 1; tick();
    check("R3 lock lost", {7'd0, rd_data[5]}, 8'd0);
    ev_lock_gain = 1; ev_sw_start = 1; tick();
    check("R3 clear beats gain", {7'd0, rd_data[5]}, 8'd0);

    // R4: masking keeps state
    ev_lock_gain = 1; tick();
    pll_is_sysclk = 0; #1;
    check("R4 masked", {7'd0, rd_data[5]}, 8'd0);
    tick();
    pll_is_sysclk = 1; #1;
    check("R4 unmasked kept", {7'd0, rd_data[5]}, 8'd1);

    // R5: cf set, write 1 no effect, write 0 clears, start clears
    ev_fail_detect = 1; tick();
    check("R5 cf set", {7'd0, rd_data[3]}, 8'd1);
    wr(8'h08); tick();
    check("R5 write 1 keeps", {7'd0, rd_data[3]}, 8'd1);
    wr(8'h00); tick();
    check("R5 write 0 clears", {7'd0, rd_data[3]}, 8'd0);
    wr(8'h08); tick();
    check("R5 write 1 no set", {7'd0, rd_data[3]}, 8'd0);
    ev_fail_detect = 1; tick();
    ev_sw_start = 1; tick();
    check("R5 start clears", {7'd0, rd_data[3]}, 8'd0);

    // R6: set beats clears
    ev_fail_detect = 1; wr(8'h00); tick();
    check("R6 set beats sw clear", {7'd0, rd_data[3]}, 8'd1);
    ev_fail_detect = 1; ev_sw_start = 1; tick();
    check("R6 set beats start", {7'd0, rd_data[3]}, 8'd1);

    // R7: request set and each clear source
    wr(8'h01); tick(); check("R7 req set", {7'd0, sw_req}, 8'd1);
    ev_sw_done = 1; tick(); check("R7 done clears", {7'd0, sw_req}, 8'd0);
    wr(8'h01); tick(); ev_sw_redundant = 1; tick();
    check("R7 redundant clears", {7'd0, sw_req}, 8'd0);
    wr(8'h01); tick(); ev_fsm_to_rc = 1; tick();
    check("R7 rc clears", {7'd0, sw_req}, 8'd0);

    // R8: clear beats write
    wr(8'h01); ev_sw_done = 1; tick();
    check("R8 clear beats set", {7'd0, sw_req}, 8'd0);
    wr(8'h01); ev_fsm_to_rc = 1; tick();
    check("R8 rc beats set", {7'd0, sw_req}, 8'd0);

    // R9: trim selection for every roll index
    wr(8'h00); tick();
    tune_fields = $urandom();
    for (int r = 0; r < 8; r++) begin
      roll_idx = r[2:0]; #1;
      check("R9 base trim", {4'd0, trim_out}, {4'd0, exp_trim(tune_fields, roll_idx, 1'b0)});
    end
    wr(8'h04); tick();
    for (int r = 0; r < 8; r++) begin
      roll_idx = r[2:0]; #1;
      check("R9 rolled trim", {4'd0, trim_out}, {4'd0, exp_trim(tune_fields, roll_idx, 1'b1)});
    end

    // Random phase over all requirements
    for (int i = 0; i < 3000; i++) begin
      ev_sw_start     = ($urandom_range(15) == 0);
      ev_sw_done      = ($urandom_range(11) == 0);
      ev_sw_redundant = ($urandom_range(11) == 0);
      ev_lock_gain    = ($urandom_range(5) == 0);
      ev_lock_lost    = ($urandom_range(9) == 0);
      ev_fail_detect  = ($urandom_range(9) == 0);
      ev_fsm_to_rc    = ($urandom_range(11) == 0);
      wr_en           = ($urandom_range(3) == 0);
      wr_data         = $urandom();
      if ($urandom_range(15) == 0) pll_is_sysclk = ~pll_is_sysclk;
      tune_fields     = $urandom();
      roll_idx        = $urandom();
      #1;
      check("R9 random trim", {4'd0, trim_out}, {4'd0, exp_trim(tune_fields, roll_idx, m_tseq)});
      tick();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule